// File: doc/BRIEF.md
# Data-Processing Execute Unit with Condition Flags

This block is the execute stage for the register-to-register and register-to-immediate data-processing class of a 32-bit RISC core. Each cycle it may accept one operation: a 4-bit opcode, a set-flags bit, a first operand, and a second operand. The second operand is built in one of two ways. It is either a register value passed through an immediate-amount barrel shifter, or a 12-bit rotated immediate. The unit returns the 32-bit result and the updated negative, zero, carry and overflow flags one cycle later.

All six arithmetic opcodes go through a single adder. Each opcode picks its own inversion of the operands and its own carry-in. The four logical opcodes do not use the adder's carry. Their carry flag comes from the shifter or from the immediate rotator. Opcodes outside the supported set are flagged as unsupported. They leave the result at zero and leave the flags untouched.

Top module: `dp_alu`

## Requirements
- R1: Opcodes 8, 9, 10, 11, 13 and 15 are unsupported. For these, out_unsupported is 1, out_result is 0 and out_flags equals in_flags. For every other opcode, out_unsupported is 0.
- R2: Let a be the first operand, b the second operand and C the incoming carry (in_flags[1]). The arithmetic opcodes compute as follows: 2 gives a+~b+1, 3 gives ~a+b+1, 4 gives a+b, 5 gives a+b+C, 6 gives a+~b+C, and 7 gives ~a+b+C. All results are taken modulo 2^32.
- R3: For arithmetic opcodes with set-flags 1, C is the carry out of the 33-bit unsigned sum. V is 1 when the signed sum of the sign-extended inputs and the carry-in does not fit in 32 bits. The shifter or rotator carry is ignored.
- R4: The logical opcodes compute as follows: 0 gives a AND b, 1 gives a XOR b, 12 gives a OR b, and 14 gives a AND NOT b.
- R5: When in_imm_form is 1, the second operand is the low 8 bits of in_imm12, zero-extended and rotated right by twice in_imm12[11:8]. The rotator carry is the incoming C when that rotate count is 0. Otherwise it is bit 31 of the rotated value.
- R6: When in_imm_form is 0, in_op_b is shifted by in_shift_amt according to in_shift_type (0 = LSL, 1 = LSR, 2 = ASR, 3 = ROR). LSL by 0 passes the value through and gives the incoming C as carry. LSR and ASR by 0 shift by 32. ROR by 0 rotates right by one through the incoming C. Otherwise the carry is the last bit shifted out (for ROR, bit 31 of the result).
- R7: For logical opcodes with set-flags 1, C is the shifter or rotator carry and V keeps its incoming value.
- R8: With set-flags 1 on a supported opcode, N is result bit 31 and Z is 1 exactly when the result is zero. With set-flags 0, out_flags equals in_flags. The flag order is {N,Z,C,V} on bits [3:0].
- R9: After reset, out_valid, out_result, out_flags and out_unsupported are all 0. Outputs appear one cycle after in_valid is high. In a cycle with in_valid low, out_valid drops to 0 the next cycle and the other outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| in_opcode | input | 4 | Data-processing opcode |
| in_set_flags | input | 1 | Update flags when 1 |
| in_imm_form | input | 1 | 1 selects the rotated immediate as second operand |
| in_op_a | input | 32 | First operand |
| in_op_b | input | 32 | Register value for the shifted second operand |
| in_shift_amt | input | 5 | Immediate shift amount |
| in_shift_type | input | 2 | Shift kind: 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| in_imm12 | input | 12 | Rotate count [11:8] and byte [7:0] |
| in_flags | input | 4 | Current flags {N,Z,C,V} |
| out_valid | output | 1 | Result valid |
| out_result | output | 32 | Operation result |
| out_flags | output | 4 | Updated flags {N,Z,C,V} |
| out_unsupported | output | 1 | Opcode outside the supported set |

## Verification
In a single cycle, both the shifter or rotator and the adder can produce a carry. The flag logic must pick the right one for the opcode class. The bench provokes this case with every arithmetic and logical opcode on register-form shifts whose shifted-out bit differs from the adder carry, and on immediates with nonzero rotate counts. It also drives the incoming carry both ways. The C flag is judged against a bench model: the adder carry for arithmetic opcodes, and the shifter or rotator carry for logical ones, where V must also be left unchanged.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,
        OP_EOR = 4'd1,
        OP_SUB = 4'd2,
        OP_RSB = 4'd3,
        OP_ADD = 4'd4,
        OP_ADC = 4'd5,
        OP_SBC = 4'd6,
        OP_RSC = 4'd7,
        OP_ORR = 4'd12,
        OP_BIC = 4'd14
    } dp_op_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_kind_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

endpackage

// File: rtl/dp_shift_imm.sv
module dp_shift_imm
    import dp_alu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]  value_i,
    input  logic [SHAMT_W-1:0] amt_i,
    input  logic [1:0]         kind_i,
    input  logic               carry_i,
    output logic [DATA_W-1:0]  value_o,
    output logic               carry_o
);
    localparam int EFF_W = SHAMT_W + 1;

    logic [EFF_W-1:0]      eff_amt;
    logic [DATA_W:0]       wide;
    logic signed [DATA_W:0] swide;
    logic [2*DATA_W-1:0]   dbl;

    always_comb begin
        eff_amt = (amt_i == '0) ? EFF_W'(DATA_W) : {1'b0, amt_i};
        wide    = '0;
        swide   = '0;
        dbl     = '0;
        value_o = value_i;
        carry_o = carry_i;
        case (shift_kind_e'(kind_i))
            SH_LSL: begin
                if (amt_i != '0) begin
                    wide    = {1'b0, value_i} << amt_i;
                    value_o = wide[DATA_W-1:0];
                    carry_o = wide[DATA_W];
                end
            end
            SH_LSR: begin
                wide    = {value_i, 1'b0} >> eff_amt;
                value_o = wide[DATA_W:1];
                carry_o = wide[0];
            end
            SH_ASR: begin
                swide   = $signed({value_i, 1'b0});
                wide    = swide >>> eff_amt;
                value_o = wide[DATA_W:1];
                carry_o = wide[0];
            end
            default: begin
                if (amt_i == '0) begin
                    value_o = {carry_i, value_i[DATA_W-1:1]};
                    carry_o = value_i[0];
                end else begin
                    dbl     = {value_i, value_i} >> amt_i;
                    value_o = dbl[DATA_W-1:0];
                    carry_o = dbl[DATA_W-1];
                end
            end
        endcase
    end

endmodule

// File: rtl/dp_imm_expand.sv
module dp_imm_expand #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 12
) (
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              carry_i,
    output logic [DATA_W-1:0] value_o,
    output logic              carry_o
);
    localparam int BYTE_W = 8;
    localparam int ROT_W  = IMM_W - BYTE_W;

    logic [ROT_W:0]        rot_amt;
    logic [DATA_W-1:0]     base;
    logic [2*DATA_W-1:0]   dbl;

    always_comb begin
        rot_amt = {imm_i[IMM_W-1:BYTE_W], 1'b0};
        base    = {{(DATA_W-BYTE_W){1'b0}}, imm_i[BYTE_W-1:0]};
        dbl     = {base, base} >> rot_amt;
        value_o = dbl[DATA_W-1:0];
        carry_o = (rot_amt == '0) ? carry_i : dbl[DATA_W-1];
    end

endmodule

// File: rtl/dp_alu_core.sv
module dp_alu_core
    import dp_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [3:0]        opcode_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              carry_i,
    output logic [DATA_W-1:0] result_o,
    output logic              add_c_o,
    output logic              add_v_o,
    output logic              is_arith_o,
    output logic              supported_o
);
    logic [DATA_W-1:0] x, y;
    logic              cin;
    logic [DATA_W:0]   sum;

    always_comb begin
        x           = a_i;
        y           = b_i;
        cin         = 1'b0;
        is_arith_o  = 1'b1;
        supported_o = 1'b1;
        case (dp_op_e'(opcode_i))
            OP_SUB: begin y = ~b_i; cin = 1'b1;    end
            OP_RSB: begin x = ~a_i; cin = 1'b1;    end
            OP_ADD: begin cin = 1'b0;              end
            OP_ADC: begin cin = carry_i;           end
            OP_SBC: begin y = ~b_i; cin = carry_i; end
            OP_RSC: begin x = ~a_i; cin = carry_i; end
            OP_AND, OP_EOR, OP_ORR, OP_BIC: is_arith_o = 1'b0;
            default: begin
                is_arith_o  = 1'b0;
                supported_o = 1'b0;
            end
        endcase

        sum     = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
        add_c_o = sum[DATA_W];
        add_v_o = (x[DATA_W-1] == y[DATA_W-1]) && (sum[DATA_W-1] != x[DATA_W-1]);

        case (dp_op_e'(opcode_i))
            OP_AND:  result_o = a_i & b_i;
            OP_EOR:  result_o = a_i ^ b_i;
            OP_ORR:  result_o = a_i | b_i;
            OP_BIC:  result_o = a_i & ~b_i;
            default: result_o = is_arith_o ? sum[DATA_W-1:0] : '0;
        endcase
    end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMM_W   = 12,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [3:0]         in_opcode,
    input  logic               in_set_flags,
    input  logic               in_imm_form,
    input  logic [DATA_W-1:0]  in_op_a,
    input  logic [DATA_W-1:0]  in_op_b,
    input  logic [SHAMT_W-1:0] in_shift_amt,
    input  logic [1:0]         in_shift_type,
    input  logic [IMM_W-1:0]   in_imm12,
    input  logic [3:0]         in_flags,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_result,
    output logic [3:0]         out_flags,
    output logic               out_unsupported
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] result;
        nzcv_t             flags;
        logic              unsupported;
    } stage_t;

    stage_t st_d, st_q;
    nzcv_t  flags_in;

    logic [DATA_W-1:0] sh_val, imm_val, op2_val, core_res;
    logic              sh_c, imm_c, op2_c;
    logic              add_c, add_v, is_arith, supported;

    assign flags_in = nzcv_t'(in_flags);

    dp_shift_imm #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
        .value_i (in_op_b),
        .amt_i   (in_shift_amt),
        .kind_i  (in_shift_type),
        .carry_i (flags_in.c),
        .value_o (sh_val),
        .carry_o (sh_c)
    );

    dp_imm_expand #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_imm (
        .imm_i   (in_imm12),
        .carry_i (flags_in.c),
        .value_o (imm_val),
        .carry_o (imm_c)
    );

    assign op2_val = in_imm_form ? imm_val : sh_val;
    assign op2_c   = in_imm_form ? imm_c   : sh_c;

    dp_alu_core #(.DATA_W(DATA_W)) u_core (
        .opcode_i    (in_opcode),
        .a_i         (in_op_a),
        .b_i         (op2_val),
        .carry_i     (flags_in.c),
        .result_o    (core_res),
        .add_c_o     (add_c),
        .add_v_o     (add_v),
        .is_arith_o  (is_arith),
        .supported_o (supported)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.unsupported = !supported;
            st_d.result      = supported ? core_res : '0;
            st_d.flags       = flags_in;
            if (supported && in_set_flags) begin
                st_d.flags.n = core_res[DATA_W-1];
                st_d.flags.z = (core_res == '0);
                st_d.flags.c = is_arith ? add_c : op2_c;
                st_d.flags.v = is_arith ? add_v : flags_in.v;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid       = st_q.valid;
    assign out_result      = st_q.result;
    assign out_flags       = st_q.flags;
    assign out_unsupported = st_q.unsupported;

    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(out_result) && $stable(out_flags));

    assert_unsupported_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_opcode inside {4'd8, 4'd9, 4'd10, 4'd11, 4'd13, 4'd15})
        |=> out_unsupported && out_result == '0 && out_flags == $past(in_flags));

    assert_no_flag_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_set_flags |=> out_flags == $past(in_flags));

    assert_nz_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_set_flags && (in_opcode inside {[4'd0:4'd7], 4'd12, 4'd14})
        |=> out_flags[3] == out_result[DATA_W-1] && out_flags[2] == (out_result == '0));

    assert_logic_keeps_v_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_opcode inside {4'd0, 4'd1, 4'd12, 4'd14})
        |=> out_flags[0] == $past(in_flags[0]));

endmodule

// File: tb/sim_dp_alu.sv
module sim_dp_alu;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_opcode = '0;
    logic        in_set_flags = 1'b0;
    logic        in_imm_form = 1'b0;
    logic [31:0] in_op_a = '0;
    logic [31:0] in_op_b = '0;
    logic [4:0]  in_shift_amt = '0;
    logic [1:0]  in_shift_type = '0;
    logic [11:0] in_imm12 = '0;
    logic [3:0]  in_flags = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic [3:0]  out_flags;
    logic        out_unsupported;

    int total = 0;
    int failed = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dp_alu u0 (
        .clk, .rst_n, .in_valid, .in_opcode, .in_set_flags, .in_imm_form,
        .in_op_a, .in_op_b, .in_shift_amt, .in_shift_type, .in_imm12, .in_flags,
        .out_valid, .out_result, .out_flags, .out_unsupported
    );

    task automatic check(input string tag, input string what, input logic [35:0] act, input logic [35:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic void model(
        input logic [3:0] op, input logic s, input logic immf,
        input logic [31:0] a, input logic [31:0] b, input logic [4:0] amt,
        input logic [1:0] typ, input logic [11:0] imm, input logic [3:0] fin,
        output logic [31:0] r, output logic [3:0] f, output logic u, output logic logical);
        logic [31:0] op2, x, y, res;
        logic sc, ci, ac, av, arith;
        logic [63:0] t, us, ss;
        int n, rot;
        ci = fin[1];
        if (immf) begin
            rot = 2 * int'(imm[11:8]);
            op2 = {24'b0, imm[7:0]};
            for (int k = 0; k < rot; k++) op2 = {op2[0], op2[31:1]};
            sc = (rot == 0) ? ci : op2[31];
        end else begin
            n = (amt == 0) ? 32 : int'(amt);
            case (typ)
                2'd0: begin
                    if (amt == 0) begin op2 = b; sc = ci; end
                    else begin t = {32'b0, b} << amt; op2 = t[31:0]; sc = t[32]; end
                end
                2'd1: begin op2 = (n == 32) ? 32'h0 : b >> n; sc = b[n-1]; end
                2'd2: begin op2 = (n == 32) ? {32{b[31]}} : 32'($signed(b) >>> n); sc = b[n-1]; end
                default: begin
                    if (amt == 0) begin op2 = {ci, b[31:1]}; sc = b[0]; end
                    else begin op2 = (b >> amt) | (b << (32 - int'(amt))); sc = op2[31]; end
                end
            endcase
        end
        arith = 1'b1; x = a; y = op2; ci = fin[1]; logical = 1'b0; u = 1'b0; res = '0;
        case (op)
            4'd2: begin y = ~op2; ci = 1'b1; end
            4'd3: begin x = ~a; ci = 1'b1; end
            4'd4: ci = 1'b0;
            4'd5: ;
            4'd6: y = ~op2;
            4'd7: x = ~a;
            4'd0: begin arith = 0; logical = 1; res = a & op2; end
            4'd1: begin arith = 0; logical = 1; res = a ^ op2; end
            4'd12: begin arith = 0; logical = 1; res = a | op2; end
            4'd14: begin arith = 0; logical = 1; res = a & ~op2; end
            default: begin arith = 0; u = 1'b1; end
        endcase
        us = {32'b0, x} + {32'b0, y} + {63'b0, ci};
        ss = {{32{x[31]}}, x} + {{32{y[31]}}, y} + {63'b0, ci};
        if (arith) res = us[31:0];
        ac = ({32'b0, us[31:0]} != us);
        av = ({{32{us[31]}}, us[31:0]} != ss);
        r = u ? 32'h0 : res;
        f = fin;
        if (!u && s) f = {res[31], res == 0, arith ? ac : sc, arith ? av : fin[0]};
    endfunction

    task automatic run_one(input logic [3:0] op, input logic s, input logic immf,
        input logic [31:0] a, input logic [31:0] b, input logic [4:0] amt,
        input logic [1:0] typ, input logic [11:0] imm, input logic [3:0] fin, input string rtag);
        logic [31:0] er; logic [3:0] ef; logic eu, lg;
        string t_res, t_flg;
        model(op, s, immf, a, b, amt, typ, imm, fin, er, ef, eu, lg);
        @(negedge clk);
        in_valid = 1; in_opcode = op; in_set_flags = s; in_imm_form = immf;
        in_op_a = a; in_op_b = b; in_shift_amt = amt; in_shift_type = typ;
        in_imm12 = imm; in_flags = fin;
        @(posedge clk); #1;
        in_valid = 0;
        t_res = (rtag != "") ? rtag : (eu ? "R1" : (lg ? "R4" : "R2"));
        t_flg = eu ? "R1" : (!s ? "R8" : (lg ? "R7" : "R3"));
        check("R9", "out_valid", 36'(out_valid), 36'd1);
        check(t_res, "result", 36'(out_result), 36'(er));
        check(t_flg, "flags", 36'(out_flags), 36'(ef));
        check("R1", "unsupported", 36'(out_unsupported), 36'(eu));
    endtask

    initial begin
        logic [31:0] apat [6];
        logic [31:0] bpat [4];
        logic [4:0]  amts [4];
        logic [7:0]  bytes [3];
        logic [31:0] held;
        apat = '{32'h0, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 32'h12345678, 32'hA5A5A5A5};
        bpat = '{32'h1, 32'hFFFFFFFF, 32'h80000000, 32'h6C3E0F81};
        amts = '{5'd0, 5'd1, 5'd4, 5'd31};
        bytes = '{8'h01, 8'h80, 8'hFF};

        repeat (3) @(posedge clk);
        #1;
        check("R9", "reset valid", 36'(out_valid), 36'd0);
        check("R9", "reset result", 36'(out_result), 36'd0);
        check("R9", "reset flags", 36'(out_flags), 36'd0);
        check("R9", "reset unsupported", 36'(out_unsupported), 36'd0);
        @(negedge clk); rst_n = 1;

        // Named corner sums
        run_one(4'd4, 1, 0, 32'h7FFFFFFF, 32'h1, 5'd0, 2'd0, 12'h0, 4'b0000, "R2");
        run_one(4'd2, 1, 0, 32'h80000000, 32'h1, 5'd0, 2'd0, 12'h0, 4'b0000, "R2");
        run_one(4'd2, 1, 0, 32'h0, 32'h1, 5'd0, 2'd0, 12'h0, 4'b0010, "R2");

        // Register-form sweep across all opcodes
        for (int op = 0; op < 16; op++)
            for (int ai = 0; ai < 6; ai++)
                for (int bi = 0; bi < 4; bi++)
                    for (int ty = 0; ty < 4; ty++)
                        for (int am = 0; am < 4; am++)
                            run_one(4'(op), ((ai + am) % 5) != 0, 1'b0, apat[ai], bpat[bi],
                                    amts[am], 2'(ty), 12'h0, 4'(ai * 3 + bi + ty), "");

        // Immediate-form sweep, every rotate value
        for (int op = 0; op < 16; op++)
            for (int rot = 0; rot < 16; rot++)
                for (int bv = 0; bv < 3; bv++)
                    for (int ai = 1; ai < 3; ai++)
                        for (int c = 0; c < 2; c++)
                            run_one(4'(op), 1'b1, 1'b1, apat[ai], 32'h0, 5'd0, 2'd0,
                                    {4'(rot), bytes[bv]}, {2'b01, 1'(c), 1'b1}, "");

        // Shifter alone: EOR with zero exposes the shifted operand
        for (int ty = 0; ty < 4; ty++)
            for (int am = 0; am < 32; am++)
                for (int bi = 0; bi < 4; bi++)
                    for (int c = 0; c < 2; c++)
                        run_one(4'd1, 1'b1, 1'b0, 32'h0, bpat[bi], 5'(am), 2'(ty), 12'h0,
                                {2'b00, 1'(c), 1'b1}, "R6");

        // Rotator alone: ORR with zero exposes the expanded immediate
        for (int rot = 0; rot < 16; rot++)
            for (int c = 0; c < 2; c++)
                run_one(4'd12, 1'b1, 1'b1, 32'h0, 32'h0, 5'd0, 2'd0, {4'(rot), 8'hC3},
                        {3'b000, 1'(c)} | {2'b00, 1'(c), 1'b0}, "R5");

        // Idle cycle holds outputs
        held = out_result;
        @(negedge clk);
        in_valid = 0; in_opcode = 4'd4; in_op_a = 32'h55; in_op_b = 32'h66;
        @(posedge clk); #1;
        check("R9", "idle valid", 36'(out_valid), 36'd0);
        check("R9", "idle result held", 36'(out_result), 36'(held));

        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        failed++;
        $display("FAIL R9 watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

endmodule